// File: doc/BRIEF.md
# Free-Running Timer with Edge Capture

The block keeps a 12-bit counter that advances on every cycle in which a 1 MHz time-base enable is high. Two single-cycle tick interrupts come from the counter: one when its low seven bits wrap (every 128 counts) and one when its low ten bits wrap (every 1024 counts). Each is gated by its own enable bit.

Two capture channels each watch one asynchronous input pin. The block synchronises each pin with two flops. On an enabled rising or falling edge it latches an 8-bit slice of the counter into that channel's rising-edge or falling-edge register. The slice is chosen by a prescale code. The capture also sets a per-register status flag, and while capture interrupts are enabled a channel's interrupt line is high as long as either of its flags is set. A small register port gives read access to the four capture registers, the configuration register and the status register. Of these, only the configuration register can be written.

Top module: `cap_timer`

## Requirements
- R1: After reset the counter, all four capture registers, the configuration register and the status register read zero, and every interrupt output is low.
- R2: The counter `timer_value` increases by one, modulo 4096, at each clock edge where `tick_1us` is high, and holds otherwise.
- R3: `irq_fast` is a one-cycle pulse that appears after the edge where the counter's low 7 bits wrap from 127 to 0, only when config bit 6 is set.
- R4: `irq_slow` is a one-cycle pulse that appears after the edge where the counter's low 10 bits wrap from 1023 to 0, only when config bit 7 is set.
- R5: A rising edge on the synchronised `cap_in[c]` with config bit 3 set stores `timer_value[k+7:k]` into channel c's rising register, where k is config bits [2:0], and values above 4 count as 4.
- R6: A falling edge on the synchronised `cap_in[c]` with config bit 4 set stores the same slice into channel c's falling register.
- R7: An edge whose direction is disabled changes neither the capture register nor the status register.
- R8: Register addresses: 0 ch0-rise, 1 ch0-fall, 2 ch1-rise, 3 ch1-fall, 4 config, 5 status, and any other address reads 0. Status bit j (j = 0..3) is set by a capture into register j and is cleared by a read of address j.
- R9: A new enabled edge overwrites the capture register even when its status flag is still set.
- R10: `irq_cap[c]` is high exactly while config bit 5 is set and status bit 2c or 2c+1 is set.
- R11: Writes to address 4 update the configuration register, which reads back unchanged. Writes to any other address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1us | input | 1 | 1 MHz time-base enable |
| cap_in | input | 2 | Asynchronous capture pins, bit c is channel c |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears a capture flag) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| timer_value | output | 12 | Free-running counter |
| irq_fast | output | 1 | 128-count tick pulse |
| irq_slow | output | 1 | 1024-count tick pulse |
| irq_cap | output | 2 | Per-channel capture interrupt |

## Verification
The bench moves the counter across many values, including through its 4095 wrap, and captures at every prescale code, including one above 4. A wrong slice shift or missing clamp would return the wrong byte. It fires an edge in a disabled direction, where a design that ignores the enable would change the register and set a flag. It fires a second edge over an unread flag, where a design that protects the old value would return a stale byte. It counts tick pulses over a full 1024-count period with the enables on and then off, so a wrong wrap bit, a stretched pulse or a missing gate shows up as a wrong count. It also checks that a write to a read-only address or to the status register leaves that register unchanged.

// File: rtl/cap_timer.sv
module cap_timer #(
  parameter int TW = 12,
  parameter int CW = 8,
  parameter int AW = 3,
  parameter int MAXK = 4,
  parameter int FAST_BITS = 7,
  parameter int SLOW_BITS = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1us,
  input  logic [1:0]    cap_in,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic [TW-1:0] timer_value,
  output logic          irq_fast,
  output logic          irq_slow,
  output logic [1:0]    irq_cap
);
  localparam int NCH = 2;
  localparam int NREG = 2 * NCH;
  localparam logic [AW-1:0] A_CFG = AW'(NREG);
  localparam logic [AW-1:0] A_STAT = AW'(NREG + 1);

  logic [TW-1:0] cnt_q;
  logic [CW-1:0] cfg_q;
  logic [NREG-1:0] flag_q;
  logic [CW-1:0] cap_q [NREG];
  logic [NCH-1:0] rise, fall;
  logic [2:0] k;
  logic [CW-1:0] win;
  logic [NREG-1:0] set_vec;

  assign k = (cfg_q[2:0] > 3'(MAXK)) ? 3'(MAXK) : cfg_q[2:0];
  assign win = CW'(cnt_q >> k);
  assign timer_value = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_fast <= 1'b0;
      irq_slow <= 1'b0;
      cfg_q <= '0;
    end else begin
      if (tick_1us) cnt_q <= cnt_q + 1'b1;
      irq_fast <= tick_1us && (&cnt_q[FAST_BITS-1:0]) && cfg_q[6];
      irq_slow <= tick_1us && (&cnt_q[SLOW_BITS-1:0]) && cfg_q[7];
      if (wr_en && addr == A_CFG) cfg_q <= wdata;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [2:0] sync_q;
    always_ff @(posedge clk) begin
      if (!rst_n) sync_q <= '0;
      else sync_q <= {sync_q[1:0], cap_in[c]};
    end
    assign rise[c] = sync_q[1] & ~sync_q[2];
    assign fall[c] = ~sync_q[1] & sync_q[2];
    assign irq_cap[c] = cfg_q[5] & (flag_q[2*c] | flag_q[2*c+1]);
  end

  for (genvar j = 0; j < NREG; j++) begin : g_reg
    if (j % 2 == 0) begin : g_rise
      assign set_vec[j] = rise[j/2] & cfg_q[3];
    end else begin : g_fall
      assign set_vec[j] = fall[j/2] & cfg_q[4];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cap_q[j] <= '0;
        flag_q[j] <= 1'b0;
      end else if (set_vec[j]) begin
        cap_q[j] <= win;
        flag_q[j] <= 1'b1;
      end else if (rd_en && addr == AW'(j)) begin
        flag_q[j] <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr < AW'(NREG)) rdata = cap_q[addr[1:0]];
    else if (addr == A_CFG) rdata = cfg_q;
    else if (addr == A_STAT) rdata = CW'(flag_q);
  end
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
  parameter int TW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_1us,
  input logic [TW-1:0] timer_value,
  input logic          irq_fast,
  input logic          irq_slow,
  input logic [1:0]    irq_cap,
  input logic [7:0]    cfg,
  input logic [3:0]    flags
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1us |=> timer_value == TW'($past(timer_value) + 1'b1));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_1us |=> $stable(timer_value));
  p_fast_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fast |=> !irq_fast);
  p_fast_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fast |-> $past(cfg[6]));
  p_slow_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_slow |=> !irq_slow);
  p_slow_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_slow |-> $past(cfg[7]));
  p_rise_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flags[0]) || $rose(flags[2])) |-> $past(cfg[3]));
  p_fall_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flags[1]) || $rose(flags[3])) |-> $past(cfg[4]));
  p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[5] |-> irq_cap == 2'b00);
  p_irq_noflag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flags == 4'b0000 |-> irq_cap == 2'b00);
endmodule

bind cap_timer cap_timer_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .timer_value(timer_value),
  .irq_fast(irq_fast), .irq_slow(irq_slow), .irq_cap(irq_cap),
  .cfg(cfg_q), .flags(flag_q)
);

// File: tb/cap_timer_test.sv
module cap_timer_test;
  logic clk = 1'b0, rst_n = 1'b0, tick_1us = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] cap_in = 2'b00;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [11:0] timer_value;
  logic irq_fast, irq_slow;
  logic [1:0] irq_cap;
  int checks = 0, errors = 0, nfast = 0, nslow = 0;
  int model = 0;
  logic [7:0] v, old;

  always #5 clk = ~clk;

  cap_timer uut (.clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .cap_in(cap_in),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .timer_value(timer_value), .irq_fast(irq_fast), .irq_slow(irq_slow), .irq_cap(irq_cap));

  always @(negedge clk) begin
    if (irq_fast) nfast++;
    if (irq_slow) nslow++;
  end

  typedef struct packed { logic [15:0] ticks; logic [2:0] ps; logic ch; logic fall; } vec_t;
  localparam vec_t VECS [7] = '{
    '{16'd300, 3'd0, 1'b0, 1'b0}, '{16'd1000, 3'd1, 1'b0, 1'b1},
    '{16'd77, 3'd2, 1'b1, 1'b0}, '{16'd2500, 3'd3, 1'b1, 1'b1},
    '{16'd3333, 3'd4, 1'b0, 1'b0}, '{16'd150, 3'd7, 1'b1, 1'b0},
    '{16'd999, 3'd5, 1'b0, 1'b1}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    if (n > 0) begin
      tick_1us = 1'b1;
      repeat (n) @(negedge clk);
      tick_1us = 1'b0;
      model = (model + n) % 4096;
    end
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d, input logic clr);
    addr = a; rd_en = clr;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic edge_to(int ch, logic lvl);
    cap_in[ch] = lvl;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] slice(int cnt, int ps);
    int kk = (ps > 4) ? 4 : ps;
    return 8'((cnt >> kk) & 255);
  endfunction

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 timer", timer_value, 0);
    chk("R1 irqs", {irq_fast, irq_slow, irq_cap}, 0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v, 1'b0);
      chk("R1 reg", v, 0);
    end

    // Table: R5 R6 R8 R10 capture at all prescale codes
    for (int i = 0; i < 7; i++) begin
      int j;
      ticks(int'(VECS[i].ticks));
      chk("R2 timer", timer_value, model);
      wr(3'd4, 8'h38 | 8'(VECS[i].ps));
      edge_to(VECS[i].ch, VECS[i].fall);
      edge_to(VECS[i].ch, ~VECS[i].fall);
      j = 2 * VECS[i].ch + VECS[i].fall;
      rd(3'd5, v, 1'b0);
      chk("R8 status set", v[j], 1);
      chk("R10 irq high", irq_cap[VECS[i].ch], 1);
      rd(3'(j), v, 1'b1);
      chk(VECS[i].fall ? "R6 fall capture" : "R5 rise capture", v, slice(model, VECS[i].ps));
      rd(3'd5, v, 1'b0);
      chk("R8 status cleared", v[j], 0);
      rd(3'(j ^ 1), v, 1'b1);
    end
    for (int a = 0; a < 4; a++) rd(3'(a), v, 1'b1);
    chk("R10 irq low no flags", irq_cap, 0);

    // R7 disabled direction
    cap_in = 2'b00; repeat (4) @(negedge clk);
    for (int a = 0; a < 4; a++) rd(3'(a), v, 1'b1);
    rd(3'd0, old, 1'b0);
    ticks(5);
    wr(3'd4, 8'h30);
    edge_to(0, 1'b1);
    rd(3'd0, v, 1'b0);
    chk("R7 reg unchanged", v, old);
    rd(3'd5, v, 1'b0);
    chk("R7 no flag", v[0], 0);
    edge_to(0, 1'b0);
    rd(3'd1, v, 1'b1);
    chk("R6 fall with rise disabled", v, slice(model, 0));

    // R9 overwrite with flag set
    wr(3'd4, 8'h38);
    edge_to(1, 1'b1);
    ticks(10);
    edge_to(1, 1'b0);
    edge_to(1, 1'b1);
    rd(3'd2, v, 1'b0);
    chk("R9 overwrite", v, slice(model, 0));

    // R10 gate
    wr(3'd4, 8'h18);
    chk("R10 irq gated off", irq_cap[1], 0);
    wr(3'd4, 8'h38);
    chk("R10 irq on", irq_cap[1], 1);

    // R11 writes
    rd(3'd2, old, 1'b0);
    wr(3'd2, 8'hAA);
    rd(3'd2, v, 1'b0);
    chk("R11 capture read-only", v, old);
    rd(3'd5, old, 1'b0);
    wr(3'd5, 8'h00);
    rd(3'd5, v, 1'b0);
    chk("R11 status read-only", v, old);
    wr(3'd4, 8'h5B);
    rd(3'd4, v, 1'b0);
    chk("R11 config readback", v, 8'h5B);
    rd(3'd6, v, 1'b0);
    chk("R8 unused addr", v, 0);

    // R3 R4 ticks from a fresh reset
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; model = 0;
    cap_in = 2'b00; repeat (4) @(negedge clk);
    wr(3'd4, 8'hC0);
    nfast = 0; nslow = 0;
    ticks(127);
    chk("R3 no early pulse", nfast, 0);
    ticks(1);
    chk("R3 pulse at wrap", nfast, 1);
    ticks(1024 - 128);
    chk("R3 fast count", nfast, 8);
    chk("R4 slow count", nslow, 1);
    wr(3'd4, 8'h00);
    nfast = 0; nslow = 0;
    ticks(1024);
    chk("R3 R4 gated", nfast + nslow, 0);
    ticks(4096 - 2048);
    chk("R2 wrap", timer_value, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule